// File: doc/BRIEF.md
# Radio Event Timer with Overflow Extension

This block is the time base that a radio link layer schedules against. A 16-bit base counter steps once per clock and restarts after a programmable number of steps. Each restart advances a 24-bit overflow counter on the same clock edge, so the pair always forms one consistent 40-bit time value. Two compare registers watch the base counter and two more watch the overflow counter. Each match produces a one-cycle event pulse, which can start a receive window, start a transmission or serve as an interrupt, and also sets a sticky flag.

A 40-bit capture register records the time when a frame-delimiter strobe or an end-of-transmission strobe arrives. Software reaches everything through a byte-wide register port. Reading the lowest time byte freezes the whole 40-bit time in a snapshot, so that the upper bytes can be read over several cycles without tearing. Flags are cleared by writing ones.

Top module: `radio_timebase`

## Requirements
- R1: After reset the base counter, overflow counter, capture register, snapshot, period, flags and event outputs are all zero.
- R2: With period register P (low byte at address 10, high byte at 11), the base counter steps 0, 1, ..., P-1, 0, ... once per clock. P = 0 means a full 65536-step cycle.
- R3: The overflow counter increases by one on the same edge on which the base counter returns to 0. The 40-bit time is {overflow, base}, overflow in the upper 24 bits.
- R4: If the period is lowered to a value at or below the current count, the base counter returns to 0 on the next edge and the overflow counter increases.
- R5: Base compare A (address 12 low, 13 high) drives evt_o[0] and base compare B (14, 15) drives evt_o[1]. Each is high for exactly the cycle in which the base counter holds the compare value after a step.
- R6: Overflow compare A (addresses 16 to 18, low byte first) drives evt_o[2] and overflow compare B (19 to 21) drives evt_o[3]. Each is high for the one cycle that follows the restart which brings the overflow counter to the compare value.
- R7: Flag bit k (register at address 22, bits 3..0, also on flag_o) is set on the edge that raises evt_o[k] and stays set. Writing 1 to bit k clears it. When a set and a clear land on the same edge, the set wins.
- R8: A high level on sfd_i or txend_i during a cycle stores that cycle's 40-bit time in the capture register (addresses 5 to 9, low byte first). The register holds its value while no strobe is seen.
- R9: A read at address 0 returns the live low time byte and latches the full 40-bit time. Addresses 1 to 4 return bytes 1 to 4 of that latched value until the next read at address 0.
- R10: Writes to the time and capture addresses (0 to 9) have no effect. Reads of unmapped addresses (23 to 31) return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; a read at address 0 latches the time |
| addr_i | input | 5 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| sfd_i | input | 1 | Frame-delimiter strobe; captures the time |
| txend_i | input | 1 | End-of-transmission strobe; captures the time |
| evt_o | output | 4 | Compare event pulses: base A, base B, overflow A, overflow B |
| flag_o | output | 4 | Sticky compare flags, same bit order as evt_o |

## Verification
The hardest condition to reach is a flag clear that lands on the same edge as a new compare hit. The bench tracks the base count in a model and issues the write-one-to-clear exactly when the count sits one step below the compare value. Overflow compares need many base restarts, so the bench shrinks the period to 20 steps. That brings several overflow increments, and with them both overflow events, within about a hundred cycles. A period lowered below the current count is produced by letting the counter run freely past the new value before writing it.

// File: rtl/rtb_pkg.sv
package rtb_pkg;
    localparam int BYTE_W  = 8;           // register port data width
    localparam int NUM_CMP = 2;           // compare registers per counter part
    localparam int NUM_EVT = 2 * NUM_CMP; // base events first, then overflow events
endpackage

// File: rtl/rtb_counter.sv
module rtb_counter #(
    parameter int CW = 16,
    parameter int OW = 24
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CW-1:0] period_i,
    output logic [CW-1:0] cnt_o,
    output logic [OW-1:0] ovf_o,
    output logic [CW-1:0] cnt_next_o,
    output logic [OW-1:0] ovf_next_o,
    output logic          wrap_o
);
    localparam logic [CW-1:0] CNT_ONE = 1;
    localparam logic [OW-1:0] OVF_ONE = 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [OW-1:0] ovf;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic wrap;

    always_comb begin
        ctr_d = ctr_q;
        // zero period selects the full binary range
        if (period_i == '0) begin
            wrap = (ctr_q.cnt == '1);
        end else begin
            wrap = (ctr_q.cnt >= period_i - CNT_ONE);
        end
        if (wrap) begin
            ctr_d.cnt = '0;
            ctr_d.ovf = ctr_q.ovf + OVF_ONE;
        end else begin
            ctr_d.cnt = ctr_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt_o      = ctr_q.cnt;
    assign ovf_o      = ctr_q.ovf;
    assign cnt_next_o = ctr_d.cnt;
    assign ovf_next_o = ctr_d.ovf;
    assign wrap_o     = wrap;
endmodule

// File: rtl/rtb_match.sv
module rtb_match #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         arm_i,
    input  logic [W-1:0] value_i,
    input  logic [W-1:0] ref_i,
    output logic         hit_d_o,
    output logic         hit_q_o
);
    typedef struct packed {
        logic hit;
    } match_t;

    match_t m_d, m_q;

    always_comb begin
        m_d.hit = arm_i && (value_i == ref_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign hit_d_o = m_d.hit;
    assign hit_q_o = m_q.hit;
endmodule

// File: rtl/rtb_capture.sv
module rtb_capture #(
    parameter int TW = 40
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          strobe_i,
    input  logic [TW-1:0] time_i,
    output logic [TW-1:0] cap_o
);
    typedef struct packed {
        logic [TW-1:0] stamp;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (strobe_i) begin
            cap_d.stamp = time_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign cap_o = cap_q.stamp;
endmodule

// File: rtl/radio_timebase.sv
module radio_timebase #(
    parameter int CW = 16,
    parameter int OW = 24,
    parameter int AW = 5
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic                                  wr_en_i,
    input  logic                                  rd_en_i,
    input  logic [AW-1:0]                         addr_i,
    input  logic [rtb_pkg::BYTE_W-1:0]            wdata_i,
    output logic [rtb_pkg::BYTE_W-1:0]            rdata_o,
    input  logic                                  sfd_i,
    input  logic                                  txend_i,
    output logic [rtb_pkg::NUM_EVT-1:0]           evt_o,
    output logic [rtb_pkg::NUM_EVT-1:0]           flag_o
);
    import rtb_pkg::*;

    // widths are whole bytes
    localparam int TW     = CW + OW;
    localparam int CB     = CW / BYTE_W;
    localparam int OB     = OW / BYTE_W;
    localparam int TB     = CB + OB;
    localparam int A_TIME = 0;
    localparam int A_CAP  = A_TIME + TB;
    localparam int A_PER  = A_CAP + TB;
    localparam int A_CMP  = A_PER + CB;
    localparam int A_OCMP = A_CMP + NUM_CMP * CB;
    localparam int A_FLAG = A_OCMP + NUM_CMP * OB;

    typedef struct packed {
        logic [CW-1:0]               period;
        logic [NUM_CMP-1:0][CW-1:0]  cmp;
        logic [NUM_CMP-1:0][OW-1:0]  ocmp;
        logic [TW-1:0]               snap;
        logic [NUM_EVT-1:0]          flags;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [CW-1:0]              cnt_w, cnt_next;
    logic [OW-1:0]              ovf_w, ovf_next;
    logic                       wrap;
    logic [TW-1:0]              time_now, cap_w;
    logic [NUM_EVT-1:0]         hit_d, clr;
    logic [CW-1:0]              period_w;
    logic [NUM_CMP-1:0][CW-1:0] cmp_w;
    logic [NUM_CMP-1:0][OW-1:0] ocmp_w;

    rtb_counter #(.CW(CW), .OW(OW)) u_counter (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .period_i   (regs_q.period),
        .cnt_o      (cnt_w),
        .ovf_o      (ovf_w),
        .cnt_next_o (cnt_next),
        .ovf_next_o (ovf_next),
        .wrap_o     (wrap)
    );

    assign time_now = {ovf_w, cnt_w};

    rtb_capture #(.TW(TW)) u_capture (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (sfd_i | txend_i),
        .time_i   (time_now),
        .cap_o    (cap_w)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        rtb_match #(.W(CW)) u_base (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .arm_i   (1'b1),
            .value_i (cnt_next),
            .ref_i   (regs_q.cmp[g]),
            .hit_d_o (hit_d[g]),
            .hit_q_o (evt_o[g])
        );
        rtb_match #(.W(OW)) u_ovf (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .arm_i   (wrap),
            .value_i (ovf_next),
            .ref_i   (regs_q.ocmp[g]),
            .hit_d_o (hit_d[NUM_CMP+g]),
            .hit_q_o (evt_o[NUM_CMP+g])
        );
    end

    always_comb begin
        regs_d = regs_q;
        clr    = '0;
        if (wr_en_i) begin
            for (int i = 0; i < CB; i++) begin
                if (addr_i == AW'(A_PER + i)) regs_d.period[i*BYTE_W +: BYTE_W] = wdata_i;
            end
            for (int c = 0; c < NUM_CMP; c++) begin
                for (int i = 0; i < CB; i++) begin
                    if (addr_i == AW'(A_CMP + c*CB + i)) regs_d.cmp[c][i*BYTE_W +: BYTE_W] = wdata_i;
                end
                for (int i = 0; i < OB; i++) begin
                    if (addr_i == AW'(A_OCMP + c*OB + i)) regs_d.ocmp[c][i*BYTE_W +: BYTE_W] = wdata_i;
                end
            end
            if (addr_i == AW'(A_FLAG)) clr = wdata_i[NUM_EVT-1:0];
        end
        if (rd_en_i && addr_i == AW'(A_TIME)) begin
            regs_d.snap = time_now;
        end
        // a new hit outranks a clear on the same edge
        regs_d.flags = (regs_q.flags & ~clr) | hit_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < TB; i++) begin
            if (addr_i == AW'(A_TIME + i)) begin
                rdata_o = (i == 0) ? time_now[BYTE_W-1:0] : regs_q.snap[i*BYTE_W +: BYTE_W];
            end
            if (addr_i == AW'(A_CAP + i)) rdata_o = cap_w[i*BYTE_W +: BYTE_W];
        end
        for (int i = 0; i < CB; i++) begin
            if (addr_i == AW'(A_PER + i)) rdata_o = regs_q.period[i*BYTE_W +: BYTE_W];
        end
        for (int c = 0; c < NUM_CMP; c++) begin
            for (int i = 0; i < CB; i++) begin
                if (addr_i == AW'(A_CMP + c*CB + i)) rdata_o = regs_q.cmp[c][i*BYTE_W +: BYTE_W];
            end
            for (int i = 0; i < OB; i++) begin
                if (addr_i == AW'(A_OCMP + c*OB + i)) rdata_o = regs_q.ocmp[c][i*BYTE_W +: BYTE_W];
            end
        end
        if (addr_i == AW'(A_FLAG)) rdata_o = {{(BYTE_W-NUM_EVT){1'b0}}, regs_q.flags};
    end

    assign flag_o   = regs_q.flags;
    assign period_w = regs_q.period;
    assign cmp_w    = regs_q.cmp;
    assign ocmp_w   = regs_q.ocmp;
endmodule

// File: rtl/rtb_checker.sv
module rtb_checker #(
    parameter int CW = 16,
    parameter int OW = 24,
    parameter int NC = 2
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic [CW-1:0]         cnt_i,
    input logic [OW-1:0]         ovf_i,
    input logic [CW-1:0]         period_i,
    input logic [NC-1:0][CW-1:0] cmp_i,
    input logic [NC-1:0][OW-1:0] ocmp_i,
    input logic [CW+OW-1:0]      cap_i,
    input logic                  sfd_i,
    input logic                  txend_i,
    input logic [2*NC-1:0]       evt_i,
    input logic [2*NC-1:0]       flag_i
);
    localparam logic [CW-1:0] CNT_ONE = 1;
    localparam logic [OW-1:0] OVF_ONE = 1;

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (cnt_i == '0) || (cnt_i == $past(cnt_i) + CNT_ONE)); // R2

    AST_OVF_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((cnt_i == '0) ? (ovf_i == $past(ovf_i) + OVF_ONE) : (ovf_i == $past(ovf_i)))); // R3

    AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_i != '0 && cnt_i < period_i) |=> (cnt_i < $past(period_i))); // R4

    AST_EVT_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i & ~flag_i) == '0); // R7

    AST_CAPTURE_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sfd_i || txend_i) |=> (cap_i == $past({ovf_i, cnt_i}))); // R8

    for (genvar g = 0; g < NC; g++) begin : g_chk
        AST_BASE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            evt_i[g] |-> (cnt_i == $past(cmp_i[g]))); // R5

        AST_OVF_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            evt_i[NC+g] |-> (cnt_i == '0 && ovf_i == $past(ocmp_i[g]))); // R6
    end
endmodule

bind radio_timebase rtb_checker #(.CW(CW), .OW(OW), .NC(rtb_pkg::NUM_CMP)) u_rtb_checker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt_w),
    .ovf_i    (ovf_w),
    .period_i (period_w),
    .cmp_i    (cmp_w),
    .ocmp_i   (ocmp_w),
    .cap_i    (cap_w),
    .sfd_i    (sfd_i),
    .txend_i  (txend_i),
    .evt_i    (evt_o),
    .flag_i   (flag_o)
);

// File: tb/test_radio_timebase.sv
module test_radio_timebase;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       sfd = 1'b0;
    logic       txend = 1'b0;
    logic [3:0] evt, flag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    radio_timebase i_radio_timebase (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .sfd_i(sfd), .txend_i(txend), .evt_o(evt), .flag_o(flag)
    );

    // requirement model of the time value (R2, R3, R4)
    logic [15:0] mc, mp;
    logic [23:0] mo;

    function automatic bit m_wraps(input logic [15:0] c, input logic [15:0] p);
        return (p == 16'd0) ? (c == 16'hFFFF) : (c >= p - 16'd1);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mc <= '0; mo <= '0; mp <= '0;
        end else begin
            if (m_wraps(mc, mp)) begin
                mc <= '0;
                mo <= mo + 24'd1;
            end else begin
                mc <= mc + 16'd1;
            end
            if (wr_en && addr == 5'd10) mp[7:0]  <= wdata;
            if (wr_en && addr == 5'd11) mp[15:8] <= wdata;
        end
    end

    // {period, cycles to run}
    localparam logic [47:0] VEC [5] = '{
        {16'd1,   32'd7},
        {16'd2,   32'd11},
        {16'd5,   32'd23},
        {16'd300, 32'd1234},
        {16'd0,   32'd65600}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; sfd = 1'b0; txend = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1;
        d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic snap(output logic [39:0] got, output logic [39:0] exp);
        logic [7:0] b;
        exp = {mo, mc};
        rd(5'd0, b);
        got[7:0] = b;
        for (int i = 1; i < 5; i++) begin
            rd(5'(i), b);
            got[i*8 +: 8] = b;
        end
    endtask

    task automatic read_cap(output logic [39:0] got);
        logic [7:0] b;
        for (int i = 0; i < 5; i++) begin
            rd(5'(5 + i), b);
            got[i*8 +: 8] = b;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [39:0] got, exp, cap_exp;
        logic [7:0]  b;
        logic [15:0] p;
        int mis [4];
        int seen [4];
        logic [3:0] e;

        // R2, R3: period table
        for (int v = 0; v < 5; v++) begin
            do_reset();
            p = VEC[v][47:32];
            wr(5'd10, p[7:0]);
            wr(5'd11, p[15:8]);
            repeat (VEC[v][31:0]) @(negedge clk);
            snap(got, exp);
            check("R2,R3 time after run", 64'(got), 64'(exp));
            if (p != 16'd0) check("R2 count below period", 64'(got[15:0] < p), 64'd1);
            else            check("R3 overflow after full cycle", 64'(got[39:16]), 64'd1);
        end

        // R1: reset state
        do_reset();
        check("R1 events", 64'(evt), 64'd0);
        check("R1 flags out", 64'(flag), 64'd0);
        rd(5'd10, b); check("R1 period low", 64'(b), 64'd0);
        rd(5'd11, b); check("R1 period high", 64'(b), 64'd0);
        rd(5'd22, b); check("R1 flag register", 64'(b), 64'd0);
        read_cap(got); check("R1 capture", 64'(got), 64'd0);
        snap(got, exp);
        check("R1 overflow zero", 64'(got[39:16]), 64'd0);
        check("R1 time vs model", 64'(got), 64'(exp));

        // R10: read-only and unmapped addresses
        wr(5'd0, 8'hAA); wr(5'd4, 8'h55); wr(5'd7, 8'hAA); wr(5'd9, 8'hFF);
        read_cap(got); check("R10 capture untouched", 64'(got), 64'd0);
        snap(got, exp); check("R10 time untouched", 64'(got), 64'(exp));
        rd(5'd23, b); check("R10 unmapped 23", 64'(b), 64'd0);
        rd(5'd31, b); check("R10 unmapped 31", 64'(b), 64'd0);

        // R4: period lowered below the running count
        do_reset();
        repeat (200) @(negedge clk);
        wr(5'd10, 8'd10);
        @(negedge clk);
        snap(got, exp);
        check("R4 immediate wrap", 64'(got), 64'h0000010000);
        repeat (25) @(negedge clk);
        snap(got, exp);
        check("R4 time vs model", 64'(got), 64'(exp));
        check("R4 count below new period", 64'(got[15:0] < 16'd10), 64'd1);

        // R5, R6: compare events with period 20
        do_reset();
        wr(5'd10, 8'd20);
        wr(5'd12, 8'd7);  wr(5'd13, 8'd0);
        wr(5'd14, 8'd13); wr(5'd15, 8'd0);
        wr(5'd16, 8'd2);  wr(5'd17, 8'd0); wr(5'd18, 8'd0);
        wr(5'd19, 8'd3);  wr(5'd20, 8'd0); wr(5'd21, 8'd0);
        rd(5'd16, b); check("R6 overflow compare readback", 64'(b), 64'd2);
        for (int k = 0; k < 4; k++) begin mis[k] = 0; seen[k] = 0; end
        for (int c = 0; c < 110; c++) begin
            @(negedge clk);
            e = {mc == 16'd0 && mo == 24'd3, mc == 16'd0 && mo == 24'd2,
                 mc == 16'd13, mc == 16'd7};
            for (int k = 0; k < 4; k++) begin
                if (evt[k] !== e[k]) mis[k]++;
                if (evt[k]) seen[k]++;
            end
        end
        check("R5 base A event timing", 64'(mis[0]), 64'd0);
        check("R5 base B event timing", 64'(mis[1]), 64'd0);
        check("R5 base A pulses seen", 64'(seen[0] >= 4), 64'd1);
        check("R6 overflow A event timing", 64'(mis[2]), 64'd0);
        check("R6 overflow B event timing", 64'(mis[3]), 64'd0);
        check("R6 overflow A pulse count", 64'(seen[2]), 64'd1);

        // R7: sticky flags and write-one-to-clear
        check("R7 flags all set", 64'(flag), 64'hF);
        rd(5'd22, b); check("R7 flag register", 64'(b), 64'h0F);
        wr(5'd13, 8'hFF); wr(5'd15, 8'hFF);
        wr(5'd22, 8'h05);
        check("R7 partial clear", 64'(flag), 64'hA);
        wr(5'd22, 8'h0A);
        rd(5'd22, b); check("R7 full clear", 64'(b), 64'h00);

        // R7: set and clear on the same edge
        wr(5'd13, 8'd0);
        while (mc != 16'd3) @(negedge clk);
        wr(5'd22, 8'h01);
        check("R7 cleared before collision", 64'(flag[0]), 64'd0);
        while (mc != 16'd6) @(negedge clk);
        wr(5'd22, 8'h01);
        check("R7 set wins over clear", 64'(flag[0]), 64'd1);
        wr(5'd13, 8'hFF);
        wr(5'd22, 8'h01);
        check("R7 clear after collision", 64'(flag), 64'd0);

        // R8: capture strobes
        do_reset();
        repeat (37) @(negedge clk);
        cap_exp = {mo, mc};
        sfd = 1'b1; @(negedge clk); sfd = 1'b0;
        read_cap(got); check("R8 frame delimiter capture", 64'(got), 64'(cap_exp));
        repeat (50) @(negedge clk);
        read_cap(got); check("R8 capture holds", 64'(got), 64'(cap_exp));
        repeat (9) @(negedge clk);
        cap_exp = {mo, mc};
        txend = 1'b1; @(negedge clk); txend = 1'b0;
        read_cap(got); check("R8 end of transmission capture", 64'(got), 64'(cap_exp));

        // R9: coherent snapshot
        do_reset();
        repeat (10) @(negedge clk);
        exp = {mo, mc};
        rd(5'd0, b);
        check("R9 live low byte", 64'(b), 64'(exp[7:0]));
        repeat (600) @(negedge clk);
        for (int i = 1; i < 5; i++) begin
            rd(5'(i), b);
            got[i*8 +: 8] = b;
        end
        check("R9 latched upper bytes", 64'(got[39:8]), 64'(exp[39:8]));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule